// File: doc/BRIEF.md
# Fault Recording Register Ring

This block keeps a log of translation faults in a small ring of fault records. Each fault event carries an 8-bit reason code, an access-type bit (read or write), a 16-bit requester source ID, a page address and a 16-bit interrupt index. The block places each event in the next record slot of the ring and sets that slot's fault flag. A global status word reports whether any record is pending, which record was the first to become pending, and whether an event was lost.

Software reads records and status through a simple request/acknowledge register port, using one 32-bit word per access. It frees a record by writing 1 to bit 31 of the record's top word. The lost-event flag is cleared by a write-one-to-clear to bit 0 of the status word.

A small controller with three states orders register accesses against record commits, so a register access never sees a record half written:

- `S_IDLE` waits for work. A register request takes it to `S_ACK`, and a held fault with no request takes it to `S_LOG`.
- `S_LOG` commits the held fault into the ring, or drops it, and then returns to `S_IDLE`.
- `S_ACK` acknowledges the register access and then returns to `S_IDLE`.

Top module: `frr_fault_ring`

## Requirements
- R1: After reset, the status word reads 0, every record word reads 0 and `flt_ready` is 1.
- R2: A logged fault fills its record as follows.
  - Word 0 holds page-address bits 31:12 in its bits 31:12, with zeros below.
  - Word 1 holds the interrupt index in bits 31:16 and page-address bits 47:32 in bits 15:0.
  - Word 2 holds the source ID in bits 15:0.
  - Word 3 holds the fault flag in bit 31, the type in bit 30 (1 = write), the reason class in bits 13:12 and the reason code in bits 7:0.
  - All other bits read 0.
- R3: Faults fill slots 0, 1, …, NUM_REC-1 in order, and the slot after NUM_REC-1 is 0.
- R4: Record i word k is read at byte address REC_BASE + 16·i + 4·k. The status word is at byte address 0.
- R5: A write to record word 3 with bit 31 set clears that record's flag. Writes to words 0 to 2, and writes with bit 31 clear, change nothing.
- R6: When the slot the next fault would fill still has its flag set, the fault is dropped: no record changes, the slot pointer holds, and status bit 0 (overflow) is set.
- R7: Writing 1 to status bit 0 clears the overflow flag.
- R8: Status bit 1 (pending) is 1 exactly while at least one record flag is set, and it falls by itself when the last flag is cleared.
- R9: Status bits 15:8 hold the slot of the fault that was logged while no flag was set. This value is held until the next such fault.
- R10: The reason class is 0 for codes below 0x20, 1 for codes 0x20 to 0x26, and 2 for codes above 0x26.
- R11: Register accesses take priority over logging. An access accepted in `S_IDLE` is acknowledged for exactly one cycle in the next cycle. A captured fault holds `flt_ready` low until it is committed.
- R12: Reads of addresses that map to neither the status word nor a record return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault event present |
| flt_ready | output | 1 | Fault holding slot is empty |
| flt_reason | input | 8 | Fault reason code |
| flt_write | input | 1 | Access type, 1 = write |
| flt_sid | input | 16 | Requester source ID |
| flt_page | input | 36 | Page address bits 47:12 |
| flt_iidx | input | 16 | Interrupt index |
| reg_req | input | 1 | Register access request, held until ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | Access done, one cycle |
| reg_rdata | output | 32 | Read data, valid with ack |

## Verification
The hardest situation to reach is a fault that arrives in the same cycle as a register request. Reaching it needs a fault to be captured while the controller is busy acknowledging, so that `flt_ready` stays low and the commit is deferred. The bench drives both inputs on the same falling edge and checks two things: the read data must show the state from before the commit, and the record must appear afterwards. Overflow is hard to reach because the ring must first be filled without any clears. The bench reaches it with directed fills and then with random streams in which faults outnumber clears.

// File: rtl/frr_pkg.sv
package frr_pkg;
    localparam int PAGE_W = 36;

    typedef enum logic [1:0] {S_IDLE, S_LOG, S_ACK} frr_state_e;

    typedef struct packed {
        logic              typ;
        logic [7:0]        reason;
        logic [1:0]        cls;
        logic [15:0]       sid;
        logic [PAGE_W-1:0] page;
        logic [15:0]       iidx;
    } frr_rec_t;

    function automatic logic [1:0] frr_class(input logic [7:0] code);
        if (code < 8'h20)       return 2'd0;
        else if (code <= 8'h26) return 2'd1;
        else                    return 2'd2;
    endfunction
endpackage

// File: rtl/frr_bank.sv
module frr_bank
    import frr_pkg::*;
#(
    parameter int NUM_REC = 4,
    localparam int IDX_W = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  frr_rec_t           wr_rec,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_REC-1:0] flags,
    output frr_rec_t           recs [NUM_REC]
);
    for (genvar i = 0; i < NUM_REC; i++) begin : g_rec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                recs[i]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                flags[i] <= 1'b1;
                recs[i]  <= wr_rec;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/frr_regmux.sv
module frr_regmux
    import frr_pkg::*;
#(
    parameter int NUM_REC  = 4,
    parameter int ADDR_W   = 8,
    parameter int REC_BASE = 32,
    localparam int IDX_W   = (NUM_REC > 1) ? $clog2(NUM_REC) : 1,
    localparam int REC_END = REC_BASE + 16 * NUM_REC
) (
    input  logic [ADDR_W-1:0]  addr,
    input  frr_rec_t           recs [NUM_REC],
    input  logic [NUM_REC-1:0] flags,
    input  logic               ovf,
    input  logic [IDX_W-1:0]   first,
    output logic               hit_stat,
    output logic               hit_rec,
    output logic [IDX_W-1:0]   rec_idx,
    output logic [1:0]         dw,
    output logic [31:0]        rdata
);
    logic [ADDR_W-1:0] off;
    frr_rec_t          r;
    logic              f;

    always_comb begin
        off      = addr - ADDR_W'(REC_BASE);
        hit_stat = (addr[ADDR_W-1:2] == '0);
        hit_rec  = (int'(addr) >= REC_BASE) && (int'(addr) < REC_END);
        rec_idx  = hit_rec ? IDX_W'(off >> 4) : '0;
        dw       = off[3:2];
        r        = recs[rec_idx];
        f        = flags[rec_idx];
        rdata    = '0;
        if (hit_stat) begin
            rdata = {16'b0, 8'(first), 6'b0, |flags, ovf};
        end else if (hit_rec) begin
            unique case (dw)
                2'd0: rdata = {r.page[19:0], 12'b0};
                2'd1: rdata = {r.iidx, r.page[35:20]};
                2'd2: rdata = {16'b0, r.sid};
                2'd3: rdata = {f, r.typ, 16'b0, r.cls, 4'b0, r.reason};
            endcase
        end
    end
endmodule

// File: rtl/frr_ctrl.sv
module frr_ctrl
    import frr_pkg::*;
#(
    parameter int NUM_REC = 4,
    localparam int IDX_W = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               hold_vld,
    input  logic [NUM_REC-1:0] flags,
    input  logic               ovf_clr,
    output frr_state_e         st,
    output logic               accept,
    output logic               commit,
    output logic               drop,
    output logic [IDX_W-1:0]   wp,
    output logic               ovf,
    output logic [IDX_W-1:0]   first
);
    frr_state_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (reg_req)       st_nx = S_ACK;
                    else if (hold_vld) st_nx = S_LOG;
            S_LOG:  st_nx = S_IDLE;
            S_ACK:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        accept = (st == S_IDLE) && reg_req;
        commit = (st == S_LOG);
        drop   = commit && flags[wp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            ovf   <= 1'b0;
            first <= '0;
        end else begin
            if (commit && !drop) begin
                wp <= (wp == IDX_W'(NUM_REC - 1)) ? '0 : wp + 1'b1;
                if (flags == '0) first <= wp;
            end
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/frr_fault_ring.sv
module frr_fault_ring
    import frr_pkg::*;
#(
    parameter int NUM_REC  = 4,
    parameter int ADDR_W   = 8,
    parameter int REC_BASE = 32,
    localparam int IDX_W   = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    output logic              flt_ready,
    input  logic [7:0]        flt_reason,
    input  logic              flt_write,
    input  logic [15:0]       flt_sid,
    input  logic [35:0]       flt_page,
    input  logic [15:0]       flt_iidx,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ack,
    output logic [31:0]       reg_rdata
);
    frr_state_e         st;
    logic               accept, commit, drop, ovf, ovf_clr, clr_en;
    logic               hold_vld, hit_stat, hit_rec;
    frr_rec_t           hold_rec;
    frr_rec_t           recs [NUM_REC];
    logic [NUM_REC-1:0] flags;
    logic [IDX_W-1:0]   wp, first, rec_idx;
    logic [1:0]         dw;
    logic [31:0]        rd_comb, rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_rec <= '0;
        end else if (commit) begin
            hold_vld <= 1'b0;
        end else if (flt_valid && !hold_vld) begin
            hold_vld <= 1'b1;
            hold_rec <= '{typ: flt_write, reason: flt_reason,
                          cls: frr_class(flt_reason), sid: flt_sid,
                          page: flt_page, iidx: flt_iidx};
        end
    end

    always_comb begin
        flt_ready = !hold_vld;
        reg_ack   = (st == S_ACK);
        reg_rdata = rdata_q;
        ovf_clr   = accept && reg_we && hit_stat && reg_wdata[0];
        clr_en    = accept && reg_we && hit_rec && (dw == 2'd3) && reg_wdata[31];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (accept && !reg_we) rdata_q <= rd_comb;
        else if (accept)            rdata_q <= '0;
    end

    frr_ctrl #(.NUM_REC(NUM_REC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .hold_vld(hold_vld),
        .flags(flags), .ovf_clr(ovf_clr), .st(st), .accept(accept),
        .commit(commit), .drop(drop), .wp(wp), .ovf(ovf), .first(first)
    );

    frr_bank #(.NUM_REC(NUM_REC)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(commit && !drop), .wr_idx(wp),
        .wr_rec(hold_rec), .clr_en(clr_en), .clr_idx(rec_idx),
        .flags(flags), .recs(recs)
    );

    frr_regmux #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W), .REC_BASE(REC_BASE)) u_mux (
        .addr(reg_addr), .recs(recs), .flags(flags), .ovf(ovf), .first(first),
        .hit_stat(hit_stat), .hit_rec(hit_rec), .rec_idx(rec_idx), .dw(dw),
        .rdata(rd_comb)
    );
endmodule

// File: rtl/frr_checker.sv
module frr_checker #(
    parameter int NUM_REC = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flt_valid,
    input logic               flt_ready,
    input logic               reg_ack,
    input logic               commit,
    input logic               drop,
    input logic [IDX_W-1:0]   wp,
    input logic [NUM_REC-1:0] flags,
    input logic               ovf,
    input logic [IDX_W-1:0]   first
);
    // R11: acknowledge lasts a single cycle
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);

    // R11: a captured fault blocks further capture
    p_hold_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_ready) |=> !flt_ready);

    // R3: the slot after the last one is slot 0
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !drop && wp == IDX_W'(NUM_REC - 1)) |=> (wp == '0));

    // R6: a dropped fault raises overflow and keeps the pointer
    p_drop_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (ovf && $stable(wp)));

    // R2: a committed fault leaves its slot flagged
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !drop) |=> flags[$past(wp)]);

    // R9: first pending slot captured when ring was idle
    p_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !drop && flags == '0) |=> (first == $past(wp)));
endmodule

bind frr_fault_ring frr_checker #(.NUM_REC(NUM_REC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .reg_ack(reg_ack), .commit(commit), .drop(drop), .wp(wp), .flags(flags),
    .ovf(ovf), .first(first)
);

// File: tb/frr_fault_ring_bench.sv
module frr_fault_ring_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int BASE = 32;

    logic        clk = 0, rst_n = 0;
    logic        flt_valid = 0, flt_write = 0;
    logic        flt_ready;
    logic [7:0]  flt_reason = 0;
    logic [15:0] flt_sid = 0, flt_iidx = 0;
    logic [35:0] flt_page = 0;
    logic        reg_req = 0, reg_we = 0, reg_ack;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;

    int n_chk = 0, n_bad = 0;

    // bench model
    logic        m_flag [N];
    logic        m_typ  [N];
    logic [7:0]  m_rsn  [N];
    logic [15:0] m_sid  [N], m_idx [N];
    logic [35:0] m_pg   [N];
    int          m_wp = 0, m_first = 0;
    logic        m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frr_fault_ring u_frr_fault_ring (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
        .flt_reason(flt_reason), .flt_write(flt_write), .flt_sid(flt_sid),
        .flt_page(flt_page), .flt_iidx(flt_iidx), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    function automatic logic [1:0] cls_of(input logic [7:0] c);
        return (c < 8'h20) ? 2'd0 : (c < 8'h27) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [31:0] exp_status();
        logic any = 0;
        for (int i = 0; i < N; i++) any |= m_flag[i];
        return {16'b0, 8'(m_first), 6'b0, any, m_ovf};
    endfunction

    function automatic logic [31:0] exp_word(input int i, input int k);
        case (k)
            0: return {m_pg[i][19:0], 12'b0};
            1: return {m_idx[i], m_pg[i][35:20]};
            2: return {16'b0, m_sid[i]};
            default: return {m_flag[i], m_typ[i], 16'b0, cls_of(m_rsn[i]), 4'b0, m_rsn[i]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rd);
        @(negedge clk);
        reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        if (!reg_ack) begin
            n_chk++; n_bad++;
            $display("FAIL R11: got ack 0 expected 1");
        end
        rd = reg_rdata;
        reg_req = 0; reg_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus(1'b0, a, 32'h0, d);
        check(req, d, exp);
    endtask

    task automatic m_commit(input logic [7:0] r, input logic t, input logic [15:0] s,
                            input logic [35:0] p, input logic [15:0] x);
        logic any = 0;
        for (int i = 0; i < N; i++) any |= m_flag[i];
        if (m_flag[m_wp]) m_ovf = 1;
        else begin
            if (!any) m_first = m_wp;
            m_flag[m_wp] = 1; m_typ[m_wp] = t; m_rsn[m_wp] = r;
            m_sid[m_wp] = s; m_pg[m_wp] = p; m_idx[m_wp] = x;
            m_wp = (m_wp == N-1) ? 0 : m_wp + 1;
        end
    endtask

    task automatic fault(input logic [7:0] r, input logic t, input logic [15:0] s,
                         input logic [35:0] p, input logic [15:0] x);
        @(negedge clk);
        flt_valid = 1; flt_reason = r; flt_write = t; flt_sid = s; flt_page = p; flt_iidx = x;
        @(negedge clk);
        flt_valid = 0;
        repeat (3) @(negedge clk);
        m_commit(r, t, s, p, x);
    endtask

    task automatic rand_fault();
        logic [7:0] r;
        case ($urandom % 4)
            0: r = 8'h1F; 1: r = 8'h20; 2: r = 8'h26;
            default: r = 8'($urandom);
        endcase
        fault(r, 1'($urandom), 16'($urandom), {4'($urandom), 32'($urandom)}, 16'($urandom));
    endtask

    task automatic clr_rec(input int i, input logic [31:0] wd);
        logic [31:0] d;
        bus(1'b1, 8'(BASE + 16*i + 12), wd, d);
        if (wd[31]) m_flag[i] = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_flag[i] = 0; m_typ[i] = 0; m_rsn[i] = 0; m_sid[i] = 0; m_idx[i] = 0; m_pg[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 ready", {31'b0, flt_ready}, 32'h1);
        rd_chk("R1 status", 8'h00, 32'h0);
        rd_chk("R1 rec3 word3", 8'(BASE + 48 + 12), 32'h0);

        // R2 R4 R10 layout of first record
        fault(8'h1F, 1'b1, 16'hBEEF, 36'h9_8765_4321, 16'hA5C3);
        for (int k = 0; k < 4; k++)
            rd_chk("R2 R4 rec0 word", 8'(BASE + 4*k), exp_word(0, k));
        rd_chk("R8 R9 status pending first=0", 8'h00, exp_status());

        // R10 class boundaries, R3 ordering
        fault(8'h20, 1'b0, 16'h0101, 36'h1, 16'h1);
        fault(8'h26, 1'b1, 16'h0202, 36'h2, 16'h2);
        fault(8'h27, 1'b0, 16'h0303, 36'h3, 16'h3);
        for (int i = 1; i < N; i++)
            rd_chk("R10 R3 class word3", 8'(BASE + 16*i + 12), exp_word(i, 3));

        // R6 overflow when next slot still flagged
        fault(8'h05, 1'b0, 16'hFFFF, 36'hF, 16'hF);
        rd_chk("R6 rec0 kept", 8'(BASE + 8), exp_word(0, 2));
        rd_chk("R6 overflow set", 8'h00, exp_status());

        // R5 clear ignores other words and bit31 clear
        bus(1'b1, 8'(BASE + 0), 32'hFFFF_FFFF, d);
        clr_rec(0, 32'h7FFF_FFFF);
        rd_chk("R5 ignored write", 8'(BASE + 12), exp_word(0, 3));
        clr_rec(0, 32'h8000_1234);
        rd_chk("R5 rec0 cleared", 8'(BASE + 12), exp_word(0, 3));
        rd_chk("R5 rec1 kept", 8'(BASE + 28), exp_word(1, 3));

        // R3 wrap into slot 0
        fault(8'h44, 1'b1, 16'h4444, 36'h4_4444_4444, 16'h4444);
        rd_chk("R3 wrap rec0", 8'(BASE + 12), exp_word(0, 3));

        // R7 overflow W1C
        bus(1'b1, 8'h00, 32'h1, d); m_ovf = 0;
        rd_chk("R7 overflow cleared", 8'h00, exp_status());

        // R8 auto clear of pending, R9 new first
        for (int i = 0; i < N; i++) clr_rec(i, 32'h8000_0000);
        rd_chk("R8 pending fell", 8'h00, exp_status());
        fault(8'h21, 1'b0, 16'h1111, 36'h5, 16'h5);
        rd_chk("R9 first pending", 8'h00, exp_status());

        // R12 unmapped
        rd_chk("R12 gap", 8'h10, 32'h0);
        rd_chk("R12 past end", 8'(BASE + 16*N), 32'h0);

        // R11 fault and request in the same cycle
        @(negedge clk);
        flt_valid = 1; flt_reason = 8'h22; flt_write = 1; flt_sid = 16'h2222;
        flt_page = 36'h6; flt_iidx = 16'h6;
        reg_req = 1; reg_we = 0; reg_addr = 8'h00;
        d = exp_status();
        @(negedge clk);
        check("R11 ack", {31'b0, reg_ack}, 32'h1);
        check("R11 ready low", {31'b0, flt_ready}, 32'h0);
        check("R11 pre-commit read", reg_rdata, d);
        flt_valid = 0; reg_req = 0;
        repeat (3) @(negedge clk);
        m_commit(8'h22, 1'b1, 16'h2222, 36'h6, 16'h6);
        check("R11 ready again", {31'b0, flt_ready}, 32'h1);
        rd_chk("R11 committed", 8'(BASE + 16*((m_wp + N - 1) % N) + 12),
               exp_word((m_wp + N - 1) % N, 3));

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 7;
            case (op)
                0, 1, 2: rand_fault();
                3: clr_rec($urandom % N, ($urandom % 4 == 0) ? 32'h0 : 32'h8000_0000);
                4: rd_chk("R8 R9 R6 status", 8'h00, exp_status());
                5: begin
                    int i = $urandom % N;
                    int k = $urandom % 4;
                    rd_chk("R2 random word", 8'(BASE + 16*i + 4*k), exp_word(i, k));
                end
                default: begin
                    bus(1'b1, 8'h00, 32'h1, d); m_ovf = 0;
                    rd_chk("R7 random clear", 8'h00, exp_status());
                end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule